// File: doc/BRIEF.md
# Data Permute, Extend and Bitfield Unit

This unit is a 32-bit datapath stage for an integer pipeline. It reorders bytes and bits, counts leading zeros, rotates an operand by a whole number of bytes and then widens a byte or halfword (signed or unsigned, optionally adding a second operand), and extracts, clears or inserts a bitfield. One operation is taken per accepted input beat, and its result appears on a registered output one cycle later.

Both edges are valid/ready streams. An input beat is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. The output register holds one result. `in_ready` is high when that register is empty, or when it is being drained in the same cycle (`out_valid` and `out_ready` both high). While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new beat is taken. Condition flags and predication are handled elsewhere.

Operand roles: `in_a` is the operand that is transformed. `in_b` is the addend of the accumulate forms. `in_dst` is the current destination value, used by clear and insert and returned by malformed bitfield requests. The rotation amount is `in_rot`×8 bits.

Top module: `bitperm_unit`

## Requirements
- R1: Op code 0 reverses all four bytes of `in_a` (byte 0 goes to byte 3, byte 1 to byte 2, and so on).
- R2: Op code 1 swaps the two bytes inside each 16-bit half of `in_a`. Op code 2 swaps the two low bytes, and the resulting 16-bit value is then sign-extended to 32 bits.
- R3: Op code 3 places bit i of `in_a` at result bit 31-i.
- R4: Op code 4 returns the number of leading zeros of `in_a`: 32 for zero, otherwise 31 minus the index of the highest set bit.
- R5: Op codes 5 (signed byte), 6 (signed halfword), 7 (unsigned byte) and 8 (unsigned halfword) rotate `in_a` right by `in_rot`×8 bits. They then take the low 8 or 16 bits and extend them to 32 bits.
- R6: When `in_acc` is 1, op codes 5 to 8 add `in_b` to the extended value, modulo 2^32.
- R7: Op codes 9 (signed) and 10 (unsigned) take the bytes at bit `in_rot`×8 and at bit (`in_rot`×8+16) mod 32. Each byte is extended to 16 bits, the first into the low half of the result and the second into the high half. With `in_acc` = 1, `in_b[15:0]` is added to the low half and `in_b[31:16]` to the high half, each modulo 2^16, with no carry passing between the halves.
- R8: Op code 11 returns `in_a[in_msb:in_lsb]` zero-extended. Op code 12 returns the same field sign-extended from its top bit.
- R9: Op code 13 returns `in_dst` with bits `in_msb:in_lsb` cleared. Op code 14 returns `in_dst` with bits `in_msb:in_lsb` replaced by the low `in_msb`-`in_lsb`+1 bits of `in_a`.
- R10: For op codes 11 to 14, when `in_msb` < `in_lsb` the result equals `in_dst`.
- R11: An accepted beat sets `out_valid` on the next edge, with the result of that beat. While `out_valid` is high and `out_ready` is low, `in_ready` is low, `out_valid` stays high and `out_result` is stable. A drained output with no new beat clears `out_valid`.
- R12: Op code 15 returns zero. `in_acc` has no effect on op codes other than 5 to 10.
- R13: During reset, `out_valid` is 0 and `out_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_op | input | 4 | Operation code (see requirements) |
| in_a | input | 32 | Operand to transform |
| in_b | input | 32 | Addend for accumulate forms |
| in_dst | input | 32 | Current destination value |
| in_rot | input | 2 | Rotation in whole bytes |
| in_acc | input | 1 | Enable accumulate on extend ops |
| in_lsb | input | 5 | Low bound of bitfield |
| in_msb | input | 5 | High bound of bitfield |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | 32 | Registered result |

## Verification
Draining the held result and accepting the next beat can happen in the same edge, and this is where a slip would lose or repeat a result. The bench stalls the output with `out_ready` low while a second beat waits. It checks that the first result and `out_valid` do not change and that `in_ready` is low. It then raises `out_ready` and checks that the very next sample carries the second beat's result. Random traffic across all op codes, with random accumulate and field bounds, is compared against a bench model. The dual-halfword carry boundary and inverted field bounds are also covered.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;
  localparam int unsigned DW  = 32;
  localparam int unsigned SW  = $clog2(DW);
  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_REV32  = 4'd0,
    OP_REV16  = 4'd1,
    OP_REVSH  = 4'd2,
    OP_BITREV = 4'd3,
    OP_LZC    = 4'd4,
    OP_SXB    = 4'd5,
    OP_SXH    = 4'd6,
    OP_UXB    = 4'd7,
    OP_UXH    = 4'd8,
    OP_SXB2   = 4'd9,
    OP_UXB2   = 4'd10,
    OP_BFXU   = 4'd11,
    OP_BFXS   = 4'd12,
    OP_BFCLR  = 4'd13,
    OP_BFINS  = 4'd14,
    OP_RSVD   = 4'd15
  } op_e;
endpackage

// File: rtl/bitperm_swap.sv
// Byte/bit reordering and leading-zero count.
module bitperm_swap
  import bitperm_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  output logic [W-1:0] res
);
  localparam int unsigned NB = W / 8;
  localparam int unsigned NH = W / 16;
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rev_word, rev_half, rev_shs, bit_rev;
  logic [CW-1:0] zcnt;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign rev_word[8*b +: 8] = a[8*(NB-1-b) +: 8];
  end

  for (genvar h = 0; h < NH; h++) begin : g_half
    assign rev_half[16*h +: 8]     = a[16*h + 8 +: 8];
    assign rev_half[16*h + 8 +: 8] = a[16*h +: 8];
  end

  assign rev_shs = {{(W-16){a[7]}}, a[7:0], a[15:8]};

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_rev[i] = a[W-1-i];
  end

  // Scan upward; the highest set bit is the last one to write.
  always_comb begin
    zcnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (a[i]) zcnt = CW'(W - 1 - i);
    end
  end

  always_comb begin
    case (op)
      OP_REV32:  res = rev_word;
      OP_REV16:  res = rev_half;
      OP_REVSH:  res = rev_shs;
      OP_BITREV: res = bit_rev;
      OP_LZC:    res = {{(W-CW){1'b0}}, zcnt};
      default:   res = '0;
    endcase
  end
endmodule

// File: rtl/bitperm_extend.sv
// Byte rotation followed by single or dual extension and optional add.
module bitperm_extend
  import bitperm_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   rot,
  input  logic         acc,
  output logic [W-1:0] res
);
  localparam int unsigned H = W / 2;

  logic [2*W-1:0] dbl;
  logic [W-1:0]   r;
  logic [W-1:0]   single, addend;
  logic [H-1:0]   lo_ext, hi_ext, lo_sum, hi_sum;
  logic           sgn;

  assign dbl = {a, a} >> {rot, 3'b000};
  assign r   = dbl[W-1:0];
  assign sgn = (op == OP_SXB2);

  always_comb begin
    case (op)
      OP_SXB:  single = {{(W-8){r[7]}}, r[7:0]};
      OP_SXH:  single = {{(W-16){r[15]}}, r[15:0]};
      OP_UXB:  single = {{(W-8){1'b0}}, r[7:0]};
      default: single = {{(W-16){1'b0}}, r[15:0]};
    endcase
  end

  assign addend = acc ? b : '0;
  assign lo_ext = {{(H-8){sgn & r[7]}}, r[7:0]};
  assign hi_ext = {{(H-8){sgn & r[H+7]}}, r[H +: 8]};
  assign lo_sum = lo_ext + addend[H-1:0];
  assign hi_sum = hi_ext + addend[W-1:H];

  always_comb begin
    case (op)
      OP_SXB, OP_SXH, OP_UXB, OP_UXH: res = single + addend;
      OP_SXB2, OP_UXB2:               res = {hi_sum, lo_sum};
      default:                        res = '0;
    endcase
  end
endmodule

// File: rtl/bitperm_field.sv
// Bitfield extract (signed/unsigned), clear and insert.
module bitperm_field
  import bitperm_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  op_e           op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  dst,
  input  logic [SW-1:0] lsb,
  input  logic [SW-1:0] msb,
  output logic [W-1:0]  res
);
  logic [W-1:0]  mask, shifted, ux, sx, ins, clr;
  logic [SW-1:0] top;
  logic          sign, bad;

  assign bad     = (msb < lsb);
  assign top     = msb - lsb;
  assign shifted = a >> lsb;
  assign sign    = a[msb];

  always_comb begin
    for (int i = 0; i < W; i++) begin
      mask[i] = (SW'(i) >= lsb) && (SW'(i) <= msb);
      ux[i]   = (SW'(i) <= top) ? shifted[i] : 1'b0;
      sx[i]   = (SW'(i) <= top) ? shifted[i] : sign;
    end
  end

  assign clr = dst & ~mask;
  assign ins = ((a << lsb) & mask) | clr;

  always_comb begin
    if (bad) begin
      res = dst;
    end else begin
      case (op)
        OP_BFXU:  res = ux;
        OP_BFXS:  res = sx;
        OP_BFCLR: res = clr;
        OP_BFINS: res = ins;
        default:  res = dst;
      endcase
    end
  end
endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit
  import bitperm_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] in_op,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  input  logic [W-1:0]   in_dst,
  input  logic [1:0]     in_rot,
  input  logic           in_acc,
  input  logic [SW-1:0]  in_lsb,
  input  logic [SW-1:0]  in_msb,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_result
);
  op_e          op;
  logic [W-1:0] swap_res, ext_res, fld_res, nxt;

  assign op = op_e'(in_op);

  bitperm_swap #(.W(W)) u_swap (
    .op  (op),
    .a   (in_a),
    .res (swap_res)
  );

  bitperm_extend #(.W(W)) u_ext (
    .op  (op),
    .a   (in_a),
    .b   (in_b),
    .rot (in_rot),
    .acc (in_acc),
    .res (ext_res)
  );

  bitperm_field #(.W(W)) u_fld (
    .op  (op),
    .a   (in_a),
    .dst (in_dst),
    .lsb (in_lsb),
    .msb (in_msb),
    .res (fld_res)
  );

  always_comb begin
    case (op)
      OP_REV32, OP_REV16, OP_REVSH, OP_BITREV, OP_LZC: nxt = swap_res;
      OP_SXB, OP_SXH, OP_UXB, OP_UXH, OP_SXB2, OP_UXB2: nxt = ext_res;
      OP_BFXU, OP_BFXS, OP_BFCLR, OP_BFINS:            nxt = fld_res;
      default:                                         nxt = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_result <= nxt;
    end
  end
endmodule

// File: rtl/bitperm_unit_chk.sv
module bitperm_unit_chk
  import bitperm_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [OPW-1:0] in_op,
  input logic [W-1:0]   in_a,
  input logic           out_valid,
  input logic           out_ready,
  input logic [W-1:0]   out_result
);
  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result));

  a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r11_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  a_r11_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r1_byte_order: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 4'd0 |=>
      out_result[7:0] == $past(in_a[W-1:W-8]) && out_result[W-1:W-8] == $past(in_a[7:0]));

  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 4'd4 |=> out_result <= W);

  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 4'd15 |=> out_result == '0);
endmodule

bind bitperm_unit bitperm_unit_chk #(.W(W)) u_chk (.*);

// File: tb/tb_bitperm_unit.sv
module tb_bitperm_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_a = '0, in_b = '0, in_dst = '0;
  logic [1:0]  in_rot = '0;
  logic        in_acc = 1'b0;
  logic [4:0]  in_lsb = '0, in_msb = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bitperm_unit dut (.*);

  function automatic logic [31:0] model(input int op, input logic [31:0] a, b, d,
                                        input int rot, input logic acc, input int lsb, msb);
    logic [31:0] r, rr, m, u;
    logic [15:0] lo, hi;
    logic [63:0] fm;
    int w;
    r = '0;
    rr = a;
    for (int k = 0; k < rot * 8; k++) rr = {rr[0], rr[31:1]};
    case (op)
      0: r = {a[7:0], a[15:8], a[23:16], a[31:24]};
      1: r = {a[23:16], a[31:24], a[7:0], a[15:8]};
      2: r = {{16{a[7]}}, a[7:0], a[15:8]};
      3: for (int i = 0; i < 32; i++) r[i] = a[31-i];
      4: begin
        r = 32;
        for (int i = 31; i >= 0; i--) if (a[i]) begin r = 32'(31 - i); break; end
      end
      5, 6, 7, 8: begin
        if (op == 5) r = {{24{rr[7]}}, rr[7:0]};
        else if (op == 6) r = {{16{rr[15]}}, rr[15:0]};
        else if (op == 7) r = {24'd0, rr[7:0]};
        else r = {16'd0, rr[15:0]};
        if (acc) r = r + b;
      end
      9, 10: begin
        lo = (op == 9) ? {{8{rr[7]}}, rr[7:0]}   : {8'd0, rr[7:0]};
        hi = (op == 9) ? {{8{rr[23]}}, rr[23:16]} : {8'd0, rr[23:16]};
        if (acc) begin lo = lo + b[15:0]; hi = hi + b[31:16]; end
        r = {hi, lo};
      end
      11, 12, 13, 14: begin
        if (msb < lsb) r = d;
        else begin
          w  = msb - lsb + 1;
          fm = (64'd1 << w) - 64'd1;
          m  = 32'(fm << lsb);
          u  = (a >> lsb) & fm[31:0];
          if (op == 11) r = u;
          else if (op == 12) r = u[w-1] ? (u | ~fm[31:0]) : u;
          else if (op == 13) r = d & ~m;
          else r = ((a << lsb) & m) | (d & ~m);
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic drive(input int op, input logic [31:0] a, b, d,
                       input int rot, input logic acc, input int lsb, msb);
    in_op = 4'(op); in_a = a; in_b = b; in_dst = d;
    in_rot = 2'(rot); in_acc = acc; in_lsb = 5'(lsb); in_msb = 5'(msb);
  endtask

  // One beat with output drained immediately; sample one cycle after acceptance.
  task automatic run(input string req, input int op, input logic [31:0] a, b, d,
                     input int rot, input logic acc, input int lsb, msb);
    @(negedge clk);
    drive(op, a, b, d, rot, acc, lsb, msb);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check(req, out_result, model(op, a, b, d, rot, acc, lsb, msb));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] ea, eb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 reset valid", 32'(out_valid), 32'd0);
    check("R13 reset result", out_result, 32'd0);
    rst_n = 1'b1;

    run("R1 byte reverse", 0, 32'h11223344, 0, 0, 0, 0, 0, 0);
    run("R2 half swap", 1, 32'hA1B2C3D4, 0, 0, 0, 0, 0, 0);
    run("R2 signed half reverse", 2, 32'h00000080, 0, 0, 0, 0, 0, 0);
    run("R3 bit reverse", 3, 32'h00000001, 0, 0, 0, 0, 0, 0);
    run("R4 zero operand", 4, 32'h0, 0, 0, 0, 0, 0, 0);
    run("R4 top bit set", 4, 32'h80000000, 0, 0, 0, 0, 0, 0);
    run("R4 low bit only", 4, 32'h1, 0, 0, 0, 0, 0, 0);
    run("R5 signed byte rot24", 5, 32'h80FF0102, 0, 0, 3, 0, 0, 0);
    run("R5 unsigned half rot8", 8, 32'h12345678, 0, 0, 1, 0, 0, 0);
    run("R6 accumulate wrap", 6, 32'h0000FFFF, 32'h00000001, 0, 0, 1, 0, 0);
    run("R7 dual no carry", 10, 32'h00FF00FF, 32'h0001FFFF, 0, 0, 1, 0, 0);
    run("R7 dual signed rot16", 9, 32'h7F0080AA, 32'h0, 0, 2, 1, 0, 0);
    run("R8 signed full width", 12, 32'h80000001, 0, 0, 0, 0, 0, 31);
    run("R8 unsigned mid field", 11, 32'hDEADBEEF, 0, 0, 0, 0, 8, 19);
    run("R9 clear", 13, 32'h0, 0, 32'hFFFFFFFF, 0, 0, 4, 11);
    run("R9 insert single bit", 14, 32'h1, 0, 32'h0, 0, 0, 31, 31);
    run("R10 inverted bounds", 11, 32'h12345678, 0, 32'hCAFEF00D, 0, 0, 9, 3);
    run("R10 inverted insert", 14, 32'hFFFFFFFF, 0, 32'h0BADBEEF, 0, 0, 20, 19);
    run("R12 reserved op", 15, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1, 1, 0, 31);
    run("R12 acc ignored", 0, 32'h01020304, 32'h10000000, 0, 0, 1, 0, 0);

    // R11 stall with a waiting beat, then drain and accept on the same edge
    ea = model(3, 32'h0000F00F, 0, 0, 0, 0, 0, 0);
    eb = model(7, 32'hAABBCCDD, 0, 0, 2, 0, 0, 0);
    @(negedge clk);
    out_ready = 1'b0;
    drive(3, 32'h0000F00F, 0, 0, 0, 0, 0, 0);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive(7, 32'hAABBCCDD, 0, 0, 2, 0, 0, 0);
    check("R11 first result", out_result, ea);
    check("R11 blocked ready", 32'(in_ready), 32'd0);
    repeat (2) @(negedge clk);
    check("R11 held valid", 32'(out_valid), 32'd1);
    check("R11 held result", out_result, ea);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 next result", out_result, eb);
    check("R11 next valid", 32'(out_valid), 32'd1);
    @(posedge clk);
    @(negedge clk);
    check("R11 drained", 32'(out_valid), 32'd0);

    // Random traffic covering R1-style ops through R12
    for (int n = 0; n < 400; n++) begin
      run("R5 R7 R8 R9 random", int'($urandom_range(15)), $urandom, $urandom, $urandom,
          int'($urandom_range(3)), 1'($urandom), int'($urandom_range(31)),
          int'($urandom_range(31)));
    end

    summary();
    $finish;
  end
endmodule